// File: doc/BRIEF.md
# Receiver Lock and Calibration Manager

This block is the per-lane supervisor for a serial receiver's clock-recovery loop. It holds the loop on the local reference until the lane shows activity. It then switches the loop to track incoming data and waits for fine lock to stay stable. Depending on its build-time calibration mode, it may run a full equalizer/CDR calibration before it declares the data valid. An external calibration engine does the actual work. The block only issues a start pulse with a job code and waits for the engine's done pulse.

Once the link is up, software-side logic can request three things: a full calibration, an incremental eye-centering pass, or an incremental coefficient pass. Each request is acted on at its rising edge. If the link breaks, shown by fine lock lost while the idle detector reports no signal, the loop falls back to the reference. It comes back when activity returns, keeps the stored calibration and runs no new calibration. The recovered clock is gated off whenever the loop sits on the reference.

The idle, fine-lock, loss-of-signal and request inputs are synchronized by two flops each. The calibration-engine done input is taken as synchronous to the control clock.

Top module: `rx_lock_mgr`

## Requirements
- R1: While reset is asserted and right after its release, the outputs are as follows: lockToData, calStart, calibrating, dataValid, eyeDone and coeffDone are 0. rxClkEn is 0, except in mode CAL_NONE (code 0), where it is 1.
- R2: In any mode other than CAL_NONE, the lane is in the reference state and lockToData is 0. When the synchronized rxIdle is low and the synchronized los is low, lockToData rises. This takes three control-clock edges after the inputs change.
- R3: While the lane is in the reference state, a high los keeps lockToData at 0 whatever rxIdle does. Once lockToData is 1, raising los has no effect on any output.
- R4: Fine lock counts as stable only after the synchronized fineLock has been high for STABLE_CYCLES consecutive cycles (default 8) while the lane acquires. Any low sample restarts the count.
- R5: In modes CAL_FIRST_AND_DEMAND (1) and CAL_STATIC_EQ (3), the first stable lock after reset issues a one-cycle calStart with calType 0 (full). calibrating stays high until calDone is seen, and dataValid follows after that.
- R6: While the link is up, a rising edge of calReq starts one full calibration (calStart with calType 0, calibrating high). lockToData stays 1 during the calibration. Holding calReq high does not start another.
- R7: dataValid is 1 only while the link is up, no calibration is running and the synchronized fineLock is high. If fine lock drops while rxIdle stays low, only dataValid falls.
- R8: If, while the link is up, fineLock is low and rxIdle is high, lockToData falls. When activity and fine lock return, the lane re-acquires a stable lock and reasserts dataValid without issuing calStart.
- R9: rxClkEn is 0 whenever the lane is in the reference state, and 1 otherwise. In mode CAL_NONE it is always 1.
- R10: A rising edge of eyeReq while the link is up runs an incremental pass with calType 1. A rising edge of coeffReq runs one with calType 2. When calDone arrives, the matching done output rises and stays high until its request is lowered.
- R11: In mode CAL_NONE, lockToData never rises and no calibration is ever started. dataValid is high once fine lock is stable.
- R12: In mode CAL_STATIC_EQ, coeffReq is ignored: no calStart is issued, coeffDone stays 0 and dataValid stays high.
- R13: In mode CAL_DEMAND_ONLY (2), a stable first lock goes straight to dataValid without a calibration.
- R14: If several requests are pending at once, they are served one after the other, in the order full, eye, coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rstN | input | 1 | Asynchronous active-low reset |
| los | input | 1 | Loss-of-signal, honoured only in the reference state |
| rxIdle | input | 1 | Receiver idle indicator, high means no activity |
| fineLock | input | 1 | CDR fine-lock indicator |
| calReq | input | 1 | Full calibration request, rising-edge acting |
| eyeReq | input | 1 | Incremental eye-centering request |
| coeffReq | input | 1 | Incremental coefficient request |
| calDone | input | 1 | Calibration engine finished the current job |
| lockToData | output | 1 | 1 selects lock-to-data, 0 lock-to-reference |
| calStart | output | 1 | One-cycle start pulse for the calibration engine |
| calType | output | 2 | Job code: 0 full, 1 eye, 2 coefficient |
| calibrating | output | 1 | Full calibration in progress |
| dataValid | output | 1 | Recovered data valid |
| eyeDone | output | 1 | Eye pass done handshake |
| coeffDone | output | 1 | Coefficient pass done handshake |
| rxClkEn | output | 1 | Recovered-clock enable, 0 forces the clock low |

## Verification
A wrong state in the controller shows up at the ports within one cycle of the state register moving. The state alone drives lockToData, rxClkEn and calibrating. A miscount in the lock-stability counter moves the calStart or dataValid edge by whole cycles, so it can only be caught by a cycle-exact comparison. A lost or doubled request edge shows up as a missing or extra calStart, or as calType values out of the expected order. Because of this, each output is compared on every cycle against an independent model of four lanes, one built in each mode.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

  typedef enum logic [1:0] {
    CAL_NONE             = 2'd0,
    CAL_FIRST_AND_DEMAND = 2'd1,
    CAL_DEMAND_ONLY      = 2'd2,
    CAL_STATIC_EQ        = 2'd3
  } calMode_e;

  typedef enum logic [2:0] {
    ST_REF,
    ST_ACQ,
    ST_CAL,
    ST_REEYE,
    ST_RECOEF,
    ST_UP
  } lmState_e;

  typedef enum logic [1:0] {
    JOB_FULL  = 2'd0,
    JOB_EYE   = 2'd1,
    JOB_COEFF = 2'd2
  } calJob_e;

  localparam int NUM_REQ   = 3;
  localparam int REQ_FULL  = 0;
  localparam int REQ_EYE   = 1;
  localparam int REQ_COEFF = 2;

  localparam int SY_LOS   = 0;
  localparam int SY_IDLE  = 1;
  localparam int SY_FINE  = 2;
  localparam int SY_REQ0  = 3;
  localparam int NUM_SYNC = SY_REQ0 + NUM_REQ;

  typedef struct packed {
    logic               countEn;
    logic [NUM_REQ-1:0] service;
    logic               setEyeDone;
    logic               setCoeffDone;
    logic               setCalibrated;
  } ctrlStrobe_t;

  typedef struct packed {
    logic               losS;
    logic               idleS;
    logic               fineS;
    logic               stable;
    logic [NUM_REQ-1:0] pending;
    logic               calibrated;
  } laneStatus_t;

endpackage

// File: rtl/rlm_sync.sv
module rlm_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/rlm_datapath.sv
module rlm_datapath
  import rlm_pkg::*;
#(
  parameter int STABLE_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        los,
  input  logic        rxIdle,
  input  logic        fineLock,
  input  logic        calReq,
  input  logic        eyeReq,
  input  logic        coeffReq,
  input  ctrlStrobe_t strb,
  output laneStatus_t stat,
  output logic        eyeDone,
  output logic        coeffDone
);

  localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STABLE_CYCLES);
  localparam logic [NUM_SYNC-1:0] SYNC_RST =
    NUM_SYNC'((1 << SY_LOS) | (1 << SY_IDLE));

  logic [NUM_SYNC-1:0] syncIn;
  logic [NUM_SYNC-1:0] syncOut;
  logic [NUM_REQ-1:0]  reqS;
  logic [NUM_REQ-1:0]  reqPrev;
  logic [NUM_REQ-1:0]  pend;
  logic [CNT_W-1:0]    lockCnt;
  logic                calibQ;

  assign syncIn = {coeffReq, eyeReq, calReq, fineLock, rxIdle, los};

  rlm_sync #(.W(NUM_SYNC), .RST_VAL(SYNC_RST)) uSync (
    .clk (clk),
    .rstN(rstN),
    .d   (syncIn),
    .q   (syncOut)
  );

  assign reqS = syncOut[SY_REQ0 +: NUM_REQ];

  // lock stability counter, saturating, cleared on any low sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockCnt <= '0;
    end else if (strb.countEn && syncOut[SY_FINE]) begin
      if (lockCnt != CNT_MAX) lockCnt <= lockCnt + 1'b1;
    end else begin
      lockCnt <= '0;
    end
  end

  // request edge capture, one lane per request kind
  for (genvar g = 0; g < NUM_REQ; g++) begin : gReq
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqPrev[g] <= 1'b0;
        pend[g]    <= 1'b0;
      end else begin
        reqPrev[g] <= reqS[g];
        pend[g]    <= reqS[g] && ((pend[g] && !strb.service[g]) || !reqPrev[g]);
      end
    end

    // R6
    serviced_only_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.service[g] |-> pend[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eyeDone   <= 1'b0;
      coeffDone <= 1'b0;
      calibQ    <= 1'b0;
    end else begin
      eyeDone   <= reqS[REQ_EYE]   && (eyeDone   || strb.setEyeDone);
      coeffDone <= reqS[REQ_COEFF] && (coeffDone || strb.setCoeffDone);
      if (strb.setCalibrated) calibQ <= 1'b1;
    end
  end

  assign stat.losS       = syncOut[SY_LOS];
  assign stat.idleS      = syncOut[SY_IDLE];
  assign stat.fineS      = syncOut[SY_FINE];
  assign stat.stable     = (lockCnt == CNT_MAX);
  assign stat.pending    = pend;
  assign stat.calibrated = calibQ;

  // R4
  stable_needs_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    stat.stable |-> $past(stat.fineS));

  // R10
  eye_done_from_job_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eyeDone) |-> $past(strb.setEyeDone));

  // R10
  coeff_done_from_job_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coeffDone) |-> $past(strb.setCoeffDone));

endmodule

// File: rtl/rlm_ctrl.sv
module rlm_ctrl
  import rlm_pkg::*;
#(
  parameter calMode_e MODE = CAL_FIRST_AND_DEMAND
) (
  input  logic        clk,
  input  logic        rstN,
  input  laneStatus_t stat,
  input  logic        calDone,
  output ctrlStrobe_t strb,
  output logic        lockToData,
  output logic        calStart,
  output logic [1:0]  calType,
  output logic        calibrating,
  output logic        dataValid,
  output logic        rxClkEn
);

  localparam bit REF_ONLY    = (MODE == CAL_NONE);
  localparam bit NEED_FIRST  = (MODE == CAL_FIRST_AND_DEMAND) || (MODE == CAL_STATIC_EQ);
  localparam bit ALLOW_COEFF = (MODE != CAL_STATIC_EQ);

  lmState_e st, nxt;
  calJob_e  jobQ, jobNxt;
  logic     startNxt;

  always_comb begin
    nxt          = st;
    strb         = '0;
    startNxt     = 1'b0;
    jobNxt       = jobQ;
    strb.countEn = (st == ST_ACQ) || REF_ONLY;
    unique case (st)
      ST_REF: begin
        if (!REF_ONLY && !stat.idleS && !stat.losS) nxt = ST_ACQ;
      end
      ST_ACQ: begin
        if (stat.idleS) begin
          nxt = ST_REF;
        end else if (stat.stable) begin
          if (NEED_FIRST && !stat.calibrated) begin
            nxt      = ST_CAL;
            startNxt = 1'b1;
            jobNxt   = JOB_FULL;
          end else begin
            nxt = ST_UP;
          end
        end
      end
      ST_CAL: begin
        if (calDone) begin
          nxt                = ST_UP;
          strb.setCalibrated = 1'b1;
        end
      end
      ST_REEYE: begin
        if (calDone) begin
          nxt             = ST_UP;
          strb.setEyeDone = 1'b1;
        end
      end
      ST_RECOEF: begin
        if (calDone) begin
          nxt               = ST_UP;
          strb.setCoeffDone = 1'b1;
        end
      end
      ST_UP: begin
        if (!stat.fineS && stat.idleS) begin
          nxt = ST_REF;
        end else if (stat.pending[REQ_FULL]) begin
          nxt                    = ST_CAL;
          startNxt               = 1'b1;
          jobNxt                 = JOB_FULL;
          strb.service[REQ_FULL] = 1'b1;
        end else if (stat.pending[REQ_EYE]) begin
          nxt                   = ST_REEYE;
          startNxt              = 1'b1;
          jobNxt                = JOB_EYE;
          strb.service[REQ_EYE] = 1'b1;
        end else if (ALLOW_COEFF && stat.pending[REQ_COEFF]) begin
          nxt                     = ST_RECOEF;
          startNxt                = 1'b1;
          jobNxt                  = JOB_COEFF;
          strb.service[REQ_COEFF] = 1'b1;
        end
      end
      default: nxt = ST_REF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_REF;
      jobQ     <= JOB_FULL;
      calStart <= 1'b0;
    end else begin
      st       <= nxt;
      jobQ     <= jobNxt;
      calStart <= startNxt;
    end
  end

  assign lockToData  = (st != ST_REF);
  assign calibrating = (st == ST_CAL);
  assign calType     = jobQ;
  assign rxClkEn     = REF_ONLY || (st != ST_REF);
  assign dataValid   = stat.fineS && (REF_ONLY ? stat.stable : (st == ST_UP));

  // R3
  los_holds_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_REF && stat.losS) |=> (st == ST_REF));

  // R5
  cal_waits_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_CAL && !calDone) |=> (st == ST_CAL));

  // R4
  acq_needs_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_ACQ && !stat.stable) |=> (st == ST_ACQ || st == ST_REF));

  // R8
  drop_to_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_UP && !stat.fineS && stat.idleS) |=> (st == ST_REF));

  // R7
  valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> stat.fineS);

  // R6
  calibrating_started_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calibrating) |-> calStart);

  // R12
  no_coeff_static_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!ALLOW_COEFF && st == ST_RECOEF));

endmodule

// File: rtl/rx_lock_mgr.sv
module rx_lock_mgr
  import rlm_pkg::*;
#(
  parameter calMode_e CAL_MODE      = CAL_FIRST_AND_DEMAND,
  parameter int       STABLE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       los,
  input  logic       rxIdle,
  input  logic       fineLock,
  input  logic       calReq,
  input  logic       eyeReq,
  input  logic       coeffReq,
  input  logic       calDone,
  output logic       lockToData,
  output logic       calStart,
  output logic [1:0] calType,
  output logic       calibrating,
  output logic       dataValid,
  output logic       eyeDone,
  output logic       coeffDone,
  output logic       rxClkEn
);

  ctrlStrobe_t strb;
  laneStatus_t stat;

  rlm_datapath #(.STABLE_CYCLES(STABLE_CYCLES)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .los      (los),
    .rxIdle   (rxIdle),
    .fineLock (fineLock),
    .calReq   (calReq),
    .eyeReq   (eyeReq),
    .coeffReq (coeffReq),
    .strb     (strb),
    .stat     (stat),
    .eyeDone  (eyeDone),
    .coeffDone(coeffDone)
  );

  rlm_ctrl #(.MODE(CAL_MODE)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .stat       (stat),
    .calDone    (calDone),
    .strb       (strb),
    .lockToData (lockToData),
    .calStart   (calStart),
    .calType    (calType),
    .calibrating(calibrating),
    .dataValid  (dataValid),
    .rxClkEn    (rxClkEn)
  );

endmodule

// File: tb/rlm_ref_model.sv
module rlm_ref_model #(
  parameter int MODE    = 1,
  parameter int STABLE  = 8,
  parameter int CAL_LAT = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       los,
  input  logic       rxIdle,
  input  logic       fineLock,
  input  logic       calReq,
  input  logic       eyeReq,
  input  logic       coeffReq,
  output logic       calDone,
  output logic [8:0] expOut
);

  // phases: 0 reference, 1 acquire, 2 full cal, 3 eye pass, 4 coeff pass, 5 link up
  int       ph;
  bit [5:0] s1, s2;
  bit [2:0] prv, pnd;
  int       cnt;
  bit       calib, stp, eD, cD;
  int       kind;
  int       left;

  always @(posedge clk or negedge rstN) begin
    bit lS, iS, fS, stable, setE, setC, setK, started;
    bit [2:0] rS, svc;
    int np, nk, nc;
    if (!rstN) begin
      ph = 0; s1 = 6'b000011; s2 = 6'b000011; prv = 0; pnd = 0;
      cnt = 0; calib = 0; stp = 0; eD = 0; cD = 0; kind = 0;
    end else begin
      lS = s2[0]; iS = s2[1]; fS = s2[2]; rS = s2[5:3];
      stable = (cnt == STABLE);
      svc = 0; started = 0; setE = 0; setC = 0; setK = 0;
      np = ph; nk = kind;
      if (ph == 0) begin
        if (MODE != 0 && !iS && !lS) np = 1;
      end else if (ph == 1) begin
        if (iS) np = 0;
        else if (stable) begin
          if ((MODE == 1 || MODE == 3) && !calib) begin np = 2; started = 1; nk = 0; end
          else np = 5;
        end
      end else if (ph >= 2 && ph <= 4) begin
        if (calDone) begin
          if (ph == 2) setK = 1;
          if (ph == 3) setE = 1;
          if (ph == 4) setC = 1;
          np = 5;
        end
      end else begin
        if (!fS && iS) np = 0;
        else if (pnd[0]) begin np = 2; started = 1; nk = 0; svc[0] = 1; end
        else if (pnd[1]) begin np = 3; started = 1; nk = 1; svc[1] = 1; end
        else if (pnd[2] && MODE != 3) begin np = 4; started = 1; nk = 2; svc[2] = 1; end
      end
      nc = ((ph == 1 || MODE == 0) && fS) ? ((cnt < STABLE) ? cnt + 1 : cnt) : 0;
      for (int i = 0; i < 3; i++)
        pnd[i] = rS[i] && ((pnd[i] && !svc[i]) || !prv[i]);
      prv = rS;
      eD = rS[1] && (eD || setE);
      cD = rS[2] && (cD || setC);
      if (setK) calib = 1;
      ph = np; cnt = nc; stp = started; kind = nk;
      s2 = s1;
      s1 = {coeffReq, eyeReq, calReq, fineLock, rxIdle, los};
    end
  end

  // calibration engine stand-in
  always @(negedge clk) begin
    if (!rstN) begin
      left = -1; calDone = 0;
    end else begin
      calDone = (left == 0);
      if (left >= 0) left = left - 1;
      if (stp) left = CAL_LAT;
    end
  end

  always_comb begin
    logic dv;
    dv = (MODE == 0) ? (cnt == STABLE && s2[2]) : (ph == 5 && s2[2]);
    expOut = {ph != 0, stp, 2'(kind), ph == 2, dv, eD, cD, (MODE == 0) || (ph != 0)};
  end

endmodule

// File: tb/tb_rx_lock_mgr.sv
module tb_rx_lock_mgr;
  import rlm_pkg::*;

  logic clk = 1'b0;
  logic rstN, los, rxIdle, fineLock, calReq, eyeReq, coeffReq;
  logic [3:0] calDoneL;
  logic [8:0] act [4];
  logic [8:0] expv [4];
  logic [1:0] typ [4];
  int nVec = 0, nMis = 0;
  int starts [4] = '{0, 0, 0, 0};
  int typeLog [$];
  bit noneL2d = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_lock_mgr #(.CAL_MODE(CAL_FIRST_AND_DEMAND)) dut (
    .clk(clk), .rstN(rstN), .los(los), .rxIdle(rxIdle), .fineLock(fineLock),
    .calReq(calReq), .eyeReq(eyeReq), .coeffReq(coeffReq), .calDone(calDoneL[0]),
    .lockToData(act[0][8]), .calStart(act[0][7]), .calType(typ[0]),
    .calibrating(act[0][4]), .dataValid(act[0][3]), .eyeDone(act[0][2]),
    .coeffDone(act[0][1]), .rxClkEn(act[0][0]));
  rx_lock_mgr #(.CAL_MODE(CAL_DEMAND_ONLY)) dutDemand (
    .clk(clk), .rstN(rstN), .los(los), .rxIdle(rxIdle), .fineLock(fineLock),
    .calReq(calReq), .eyeReq(eyeReq), .coeffReq(coeffReq), .calDone(calDoneL[1]),
    .lockToData(act[1][8]), .calStart(act[1][7]), .calType(typ[1]),
    .calibrating(act[1][4]), .dataValid(act[1][3]), .eyeDone(act[1][2]),
    .coeffDone(act[1][1]), .rxClkEn(act[1][0]));
  rx_lock_mgr #(.CAL_MODE(CAL_NONE)) dutNone (
    .clk(clk), .rstN(rstN), .los(los), .rxIdle(rxIdle), .fineLock(fineLock),
    .calReq(calReq), .eyeReq(eyeReq), .coeffReq(coeffReq), .calDone(calDoneL[2]),
    .lockToData(act[2][8]), .calStart(act[2][7]), .calType(typ[2]),
    .calibrating(act[2][4]), .dataValid(act[2][3]), .eyeDone(act[2][2]),
    .coeffDone(act[2][1]), .rxClkEn(act[2][0]));
  rx_lock_mgr #(.CAL_MODE(CAL_STATIC_EQ)) dutStatic (
    .clk(clk), .rstN(rstN), .los(los), .rxIdle(rxIdle), .fineLock(fineLock),
    .calReq(calReq), .eyeReq(eyeReq), .coeffReq(coeffReq), .calDone(calDoneL[3]),
    .lockToData(act[3][8]), .calStart(act[3][7]), .calType(typ[3]),
    .calibrating(act[3][4]), .dataValid(act[3][3]), .eyeDone(act[3][2]),
    .coeffDone(act[3][1]), .rxClkEn(act[3][0]));

  assign act[0][6:5] = typ[0];
  assign act[1][6:5] = typ[1];
  assign act[2][6:5] = typ[2];
  assign act[3][6:5] = typ[3];

  rlm_ref_model #(.MODE(1)) mdl0 (.clk(clk), .rstN(rstN), .los(los), .rxIdle(rxIdle),
    .fineLock(fineLock), .calReq(calReq), .eyeReq(eyeReq), .coeffReq(coeffReq),
    .calDone(calDoneL[0]), .expOut(expv[0]));
  rlm_ref_model #(.MODE(2)) mdl1 (.clk(clk), .rstN(rstN), .los(los), .rxIdle(rxIdle),
    .fineLock(fineLock), .calReq(calReq), .eyeReq(eyeReq), .coeffReq(coeffReq),
    .calDone(calDoneL[1]), .expOut(expv[1]));
  rlm_ref_model #(.MODE(0)) mdl2 (.clk(clk), .rstN(rstN), .los(los), .rxIdle(rxIdle),
    .fineLock(fineLock), .calReq(calReq), .eyeReq(eyeReq), .coeffReq(coeffReq),
    .calDone(calDoneL[2]), .expOut(expv[2]));
  rlm_ref_model #(.MODE(3)) mdl3 (.clk(clk), .rstN(rstN), .los(los), .rxIdle(rxIdle),
    .fineLock(fineLock), .calReq(calReq), .eyeReq(eyeReq), .coeffReq(coeffReq),
    .calDone(calDoneL[3]), .expOut(expv[3]));

  function automatic string tagOf(input logic [8:0] diff);
    if (diff[8]) return "R2";
    if (diff[7]) return "R5";
    if (diff[6:5] != 0) return "R14";
    if (diff[4]) return "R6";
    if (diff[3]) return "R7";
    if (diff[2:1] != 0) return "R10";
    return "R9";
  endfunction

  task automatic chk(input string tag, input int actual, input int expected);
    nVec++;
    if (actual != expected) begin
      nMis++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // every-cycle comparison of all four lanes against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int l = 0; l < 4; l++) begin
        nVec++;
        if (act[l] !== expv[l]) begin
          nMis++;
          $display("FAIL %s lane%0d actual=%b expected=%b", tagOf(act[l] ^ expv[l]),
                   l, act[l], expv[l]);
        end
        if (act[l][7]) starts[l]++;
      end
      if (act[0][7]) typeLog.push_back(int'(typ[0]));
      if (act[2][8]) noneL2d = 1;
    end
  end

  task automatic finishRun();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nMis);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nMis++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int s0, sS, base;
    rstN = 0; los = 1; rxIdle = 1; fineLock = 0; calReq = 0; eyeReq = 0; coeffReq = 0;
    waitCyc(3);
    chk("R1 lockToData in reset", int'(act[0][8]), 0);
    chk("R1 rxClkEn in reset", int'(act[0][0]), 0);
    chk("R1 rxClkEn none-mode in reset", int'(act[2][0]), 1);
    rstN = 1;
    waitCyc(2);
    chk("R1 calibrating after reset", int'(act[0][4]), 0);
    chk("R1 dataValid after reset", int'(act[0][3]), 0);

    rxIdle = 0;
    waitCyc(20);
    chk("R3 los holds reference", int'(act[0][8]), 0);
    chk("R9 clock gated in reference", int'(act[0][0]), 0);

    los = 0;
    waitCyc(4);
    chk("R2 lock-to-data on activity", int'(act[0][8]), 1);
    chk("R9 clock running in lock-to-data", int'(act[0][0]), 1);
    chk("R11 none-mode stays reference", int'(act[2][8]), 0);

    fineLock = 1; waitCyc(5);
    fineLock = 0; waitCyc(2);
    fineLock = 1; waitCyc(6);
    chk("R4 dropout restarts stability count", starts[0], 0);

    waitCyc(40);
    chk("R5 first-lock calibration issued", starts[0], 1);
    chk("R5 dataValid after first cal", int'(act[0][3]), 1);
    chk("R13 demand-only skips first cal", starts[1], 0);
    chk("R13 demand-only dataValid", int'(act[1][3]), 1);
    chk("R11 none-mode dataValid", int'(act[2][3]), 1);

    los = 1;
    waitCyc(10);
    chk("R3 los ignored in lock-to-data", int'(act[0][8]), 1);
    chk("R3 los ignored dataValid", int'(act[0][3]), 1);
    los = 0;

    calReq = 1;
    waitCyc(6);
    chk("R6 calibrating on request", int'(act[0][4]), 1);
    chk("R6 stays lock-to-data", int'(act[0][8]), 1);
    waitCyc(30);
    chk("R6 held request starts once", starts[0], 2);
    calReq = 0;
    waitCyc(5);

    eyeReq = 1;
    waitCyc(30);
    chk("R10 eyeDone raised", int'(act[0][2]), 1);
    eyeReq = 0;
    waitCyc(5);
    chk("R10 eyeDone cleared", int'(act[0][2]), 0);

    sS = starts[3];
    coeffReq = 1;
    waitCyc(30);
    chk("R10 coeffDone raised", int'(act[0][1]), 1);
    chk("R12 static coeffDone stays low", int'(act[3][1]), 0);
    chk("R12 static no start", starts[3], sS);
    chk("R12 static dataValid kept", int'(act[3][3]), 1);
    coeffReq = 0;
    waitCyc(5);

    base = typeLog.size();
    calReq = 1; eyeReq = 1; coeffReq = 1;
    waitCyc(100);
    chk("R14 three jobs served", typeLog.size() - base, 3);
    if (typeLog.size() - base == 3) begin
      chk("R14 first job full", typeLog[base], 0);
      chk("R14 second job eye", typeLog[base + 1], 1);
      chk("R14 third job coeff", typeLog[base + 2], 2);
    end
    calReq = 0; eyeReq = 0; coeffReq = 0;
    waitCyc(5);

    fineLock = 0;
    waitCyc(6);
    chk("R7 dataValid drops with lock", int'(act[0][3]), 0);
    chk("R7 still lock-to-data", int'(act[0][8]), 1);
    fineLock = 1;
    waitCyc(5);
    chk("R7 dataValid returns", int'(act[0][3]), 1);

    s0 = starts[0];
    fineLock = 0; rxIdle = 1;
    waitCyc(6);
    chk("R8 fallback to reference", int'(act[0][8]), 0);
    chk("R9 clock gated after fallback", int'(act[0][0]), 0);
    waitCyc(10);
    rxIdle = 0; fineLock = 1;
    waitCyc(30);
    chk("R8 re-acquired", int'(act[0][8]), 1);
    chk("R8 dataValid after recovery", int'(act[0][3]), 1);
    chk("R8 no recalibration", starts[0], s0);
    chk("R11 none-mode never lock-to-data", int'(noneL2d), 0);
    chk("R11 none-mode no starts", starts[2], 0);

    waitCyc(2);
    finishRun();
  end

endmodule